// File: doc/BRIEF.md
# ADC Parallel Output Formatter

This block sits between a sampling converter core and its digital output pins. Each clock it takes one sample, 14 bits wide by default or 12 bits through a parameter. It can apply two optional encodings that reduce switching noise, then drives the result onto a parallel output bus. It also produces a forwarded clock for the receiver.

The first encoding is an LSB-keyed scrambler: every bit above bit 0 is XORed with bit 0. The second encoding inverts the odd-numbered lines. A receiver undoes both encodings with the same operations applied in reverse order.

The bus runs in one of two modes. In full-rate mode there is one output line per bit. In double-data-rate mode only half the lines carry data, and each of those lines carries two bits per clock, one in each clock phase.

The mode and the encoding enables are static. They are captured only while the synchronous reset `srst` is high.

Top module: `adc_out_formatter`

## Requirements
- R1: While `rst_n` is low, and while `srst` is high, the data register is cleared and `dout` is all zeros. An asynchronous reset also returns the captured configuration to full-rate mode with both encodings off.
- R2: In full-rate mode, `dout` holds the encoded form of the sample presented at a rising clock edge. It holds that value from just after the edge until the next rising edge, which gives one cycle of latency.
- R3: With only the scrambler enabled, `dout[0]` equals sample bit 0. Every bit i ≥ 1 of `dout` equals sample bit i XOR sample bit 0.
- R4: With only polarity inversion enabled, the bits at odd positions (1, 3, 5, …) are inverted and the bits at even positions pass unchanged.
- R5: With both encodings enabled, the scrambler is applied first and the odd-bit inversion second.
- R6: In double-data-rate mode, with DATA_W/2 lines, line k carries encoded bit 2k while `clk` is high after the capturing edge. It carries encoded bit 2k+1 during the following low phase. Lines DATA_W/2 and above are held at 0.
- R7: `cfg_ddr`, `cfg_rand` and `cfg_abp` are captured only while `srst` is high. Changes to them while `srst` is low have no effect on `dout`.
- R8: `dclk_out` is the inverse of `clk` in full-rate mode, so its rising edge falls mid-way through each data word. In double-data-rate mode it follows `clk`, edge-aligned with each half-bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| srst | input | 1 | Synchronous reset; configuration is captured while high |
| cfg_ddr | input | 1 | 1 selects double-data-rate mode, 0 full-rate |
| cfg_rand | input | 1 | Enables the LSB-keyed scrambler |
| cfg_abp | input | 1 | Enables odd-bit polarity inversion |
| smp_in | input | DATA_W | Converter sample, one per clock |
| dout | output | DATA_W | Parallel output lines |
| dclk_out | output | 1 | Forwarded data clock |

## Verification
The assertions assume that `smp_in` is stable at each rising clock edge. They also assume that the configuration is only meaningful once `srst` has been low for a full cycle after the internal reset releases. Under those conditions, the previous cycle's sample determines the full-rate output.

The stimulus changes inputs only in the clock's low phase. It toggles the configuration inputs only after `srst` has dropped, so the captured configuration never changes during a sweep. Each of the eight mode and encoding combinations is then swept over every 14-bit code value, and both clock phases are sampled.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_DDR  = 1'b1
  } out_mode_e;

  typedef struct packed {
    out_mode_e mode;
    logic      rand_en;
    logic      abp_en;
  } fmt_cfg_t;

  localparam fmt_cfg_t CFG_RESET = '{mode: MODE_FULL, rand_en: 1'b0, abp_en: 1'b0};

endpackage

// File: rtl/adc_fmt_encoder.sv
module adc_fmt_encoder #(
  parameter int DATA_W = 14
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              rand_on,
  input  logic              abp_on,
  output logic [DATA_W-1:0] enc
);

  logic [DATA_W-1:0] scr;

  // Stage 1: scramble with bit 0; stage 2: invert odd positions.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign scr[i] = raw[i];
    end else begin : g_upper
      assign scr[i] = raw[i] ^ (rand_on & raw[0]);
    end
    if ((i % 2) == 1) begin : g_odd
      assign enc[i] = scr[i] ^ abp_on;
    end else begin : g_even
      assign enc[i] = scr[i];
    end
  end

endmodule

// File: rtl/adc_fmt_lane_mux.sv
module adc_fmt_lane_mux #(
  parameter int DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              ddr_on,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] lines,
  output logic              fwd_clk
);

  localparam int LINES = DATA_W / 2;

  for (genvar k = 0; k < DATA_W; k++) begin : g_line
    if (k < LINES) begin : g_shared
      assign lines[k] = ddr_on ? (clk_i ? word[2*k] : word[2*k+1]) : word[k];
    end else begin : g_upper
      assign lines[k] = ddr_on ? 1'b0 : word[k];
    end
  end

  // Full-rate: centre-aligned; double-data-rate: edge-aligned.
  assign fwd_clk = ddr_on ? clk_i : ~clk_i;

endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
  import adc_fmt_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              cfg_ddr,
  input  logic              cfg_rand,
  input  logic              cfg_abp,
  input  logic [DATA_W-1:0] smp_in,
  output logic [DATA_W-1:0] dout,
  output logic              dclk_out
);

  // Reset synchroniser: asserted asynchronously, released on clk.
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // Static configuration, loaded only under synchronous reset.
  fmt_cfg_t cfg_q, cfg_d;
  logic     cfg_en;

  always_comb begin
    cfg_en        = srst;
    cfg_d.mode    = cfg_ddr ? MODE_DDR : MODE_FULL;
    cfg_d.rand_en = cfg_rand;
    cfg_d.abp_en  = cfg_abp;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cfg_q <= CFG_RESET;
    else if (cfg_en)  cfg_q <= cfg_d;
  end

  // Encode and register the sample.
  logic [DATA_W-1:0] enc, word_d, word_q;
  logic              ddr_on;

  adc_fmt_encoder #(.DATA_W(DATA_W)) u_enc (
    .raw     (smp_in),
    .rand_on (cfg_q.rand_en),
    .abp_on  (cfg_q.abp_en),
    .enc     (enc)
  );

  always_comb begin
    word_d = srst ? '0 : enc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) word_q <= '0;
    else             word_q <= word_d;
  end

  assign ddr_on = (cfg_q.mode == MODE_DDR);

  adc_fmt_lane_mux #(.DATA_W(DATA_W)) u_mux (
    .clk_i   (clk),
    .ddr_on  (ddr_on),
    .word    (word_q),
    .lines   (dout),
    .fwd_clk (dclk_out)
  );

endmodule

// File: rtl/adc_out_formatter_chk.sv
module adc_out_formatter_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic              srst,
  input logic [DATA_W-1:0] smp_in,
  input logic [DATA_W-1:0] dout,
  input logic              ddr_on,
  input logic              rand_on,
  input logic              abp_on
);

  localparam int LINES = DATA_W / 2;

  function automatic logic [DATA_W-1:0] odd_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 1; i < DATA_W; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] ODD  = odd_mask();
  localparam logic [DATA_W-1:0] UPPR = ~{{(DATA_W-1){1'b0}}, 1'b1};

  logic running;
  assign running = rst_sync_n && !srst;

  AST_CLEAR_AFTER_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst) |-> dout == '0); // R1

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && !srst) |=> ($stable(ddr_on) && $stable(rand_on) && $stable(abp_on))); // R7

  AST_FULL_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !ddr_on && !rand_on && !abp_on) |-> dout == $past(smp_in)); // R2

  AST_FULL_SCRAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !ddr_on && rand_on && !abp_on)
      |-> (dout ^ $past(smp_in)) == (UPPR & {DATA_W{$past(smp_in[0])}})); // R3

  AST_FULL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !ddr_on && !rand_on && abp_on)
      |-> (dout ^ $past(smp_in)) == ODD); // R4

  AST_FULL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !ddr_on && rand_on && abp_on)
      |-> (dout ^ $past(smp_in)) == (ODD ^ (UPPR & {DATA_W{$past(smp_in[0])}}))); // R5

  AST_DDR_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_on |-> dout[DATA_W-1:LINES] == '0); // R6

endmodule

bind adc_out_formatter adc_out_formatter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .srst       (srst),
  .smp_in     (smp_in),
  .dout       (dout),
  .ddr_on     (ddr_on),
  .rand_on    (cfg_q.rand_en),
  .abp_on     (cfg_q.abp_en)
);

// File: tb/tb_adc_out_formatter.sv
`timescale 1ns/1ps
module tb_adc_out_formatter;

  localparam int W = 14;
  localparam int L = W / 2;

  logic         clk = 1'b0;
  logic         rst_n, srst, cfg_ddr, cfg_rand, cfg_abp;
  logic [W-1:0] smp_in;
  logic [W-1:0] dout;
  logic         dclk_out;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  adc_out_formatter #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .srst(srst), .cfg_ddr(cfg_ddr),
    .cfg_rand(cfg_rand), .cfg_abp(cfg_abp), .smp_in(smp_in),
    .dout(dout), .dclk_out(dclk_out)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expect_enc(logic [W-1:0] v, logic r, logic a);
    logic [W-1:0] e;
    e = v;
    if (r) for (int i = 1; i < W; i++) e[i] = v[i] ^ v[0];
    if (a) for (int i = 1; i < W; i += 2) e[i] = ~e[i];
    return e;
  endfunction

  function automatic logic [W-1:0] ddr_phase(logic [W-1:0] e, int ph);
    logic [W-1:0] o;
    o = '0;
    for (int k = 0; k < L; k++) o[k] = e[2*k+ph];
    return o;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; srst = 1'b0; smp_in = '0;
    cfg_ddr = 1'b1; cfg_rand = 1'b1; cfg_abp = 1'b1;
    @(posedge clk); #2;
    check("R1 reset data", dout, '0);
    check("R8 reset fwd clock", {{(W-1){1'b0}}, dclk_out}, {{(W-1){1'b0}}, ~clk});
    @(negedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // srst low: configuration inputs ignored, reset config is raw full-rate
    smp_in = 14'h2A5B;
    @(posedge clk); #2;
    check("R1 reset config full/plain", dout, 14'h2A5B);
    @(negedge clk); #1;

    for (int c = 0; c < 8; c++) begin
      logic d, r, a;
      d = c[2]; r = c[0]; a = c[1];
      srst = 1'b1; cfg_ddr = d; cfg_rand = r; cfg_abp = a;
      repeat (2) @(posedge clk);
      #2;
      check("R1 srst clears", dout, '0);
      @(negedge clk); #1;
      srst = 1'b0;
      // R7: flip configuration inputs after capture
      cfg_ddr = ~d; cfg_rand = ~r; cfg_abp = ~a;
      for (int v = 0; v < (1 << W); v++) begin
        logic [W-1:0] e;
        smp_in = v[W-1:0];
        e = expect_enc(v[W-1:0], r, a);
        @(posedge clk); #2;
        if (!d) begin
          check(r && a ? "R5 full hi" : r ? "R3 full hi" : a ? "R4 full hi" : "R2 full hi", dout, e);
          check("R8 full fwd clk low", {{(W-1){1'b0}}, dclk_out}, '0);
        end else begin
          check("R6 ddr rising bits", dout, ddr_phase(e, 0));
          check("R8 ddr fwd clk high", {{(W-1){1'b0}}, dclk_out}, {{(W-1){1'b0}}, 1'b1});
        end
        @(negedge clk); #1;
        if (!d) check("R2 R7 full lo", dout, e);
        else    check("R6 R7 ddr falling bits", dout, ddr_phase(e, 1));
      end
    end

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule